// File: doc/BRIEF.md
# Receiver Control Register Bank with Layered Reset

This block holds the configuration of a digital audio receiver and turns it into the enables and resets that the receive path uses. A host reads and writes it over a simple single-cycle parallel bus with an address, write data, a write strobe, a read strobe and registered read data. The bus has no wait states.

The block has three levels of shutdown. An active-low hard power-down pin returns every field to its default, turns both clock enables off and shuts the bus. Its release is resynchronised before the bus opens again. A soft-reset bit clears everything except a protected group of clocking fields. While it is active it refuses writes to the unprotected fields, keeps the internal timing in reset and forces the serial data output low, but clocks keep running. A power bit stops only the PLL clock enable and leaves all register contents and bus access as they are.

The other two controls are an input-select field and a user-bit output enable. The input-select field picks one of two receiver inputs. The user-bit output enable gates the recovered user data bit onto its own pin.

Top module: `rcv_ctrl_regs`

## Requirements
- R1: While `pdn_n` is 0 at a clock edge, after the next edge `xtal_clk_en` and `pll_clk_en` are 0, `timing_rst` and `sdata_force_low` are 1, `rx_sel` and `user_bit_out` are 0, and all fields hold their defaults.
- R2: Register 0 layout: bit 0 soft-reset (active-low), bit 1 power (active-low), bits 3:2 crystal select, bit 4 external clock, bits 7:5 read as 0. Register 1 layout: bit 0 input select, bit 1 user-output enable, other bits read as 0. Defaults: register 0 = 0x03, register 1 = 0x00. Any other address reads 0 and ignores writes.
- R3: While the soft-reset bit is 0, register 1 reads 0 and writes to it are ignored. Register 0 stays writable, and every register stays readable.
- R4: While the soft-reset bit is 0 (and no power-down), `sdata_force_low` and `timing_rst` are 1 and `xtal_clk_en` stays 1.
- R5: While the power bit is 0 (and no power-down), `pll_clk_en` is 0 and `xtal_clk_en` is 1. Register contents are kept, and reads and writes work normally.
- R6: `rx_sel` equals the input-select bit: 0 selects receiver input 0, 1 selects receiver input 1.
- R7: `user_bit_out` follows `user_bit_in` when the user-output enable bit is 1 and is 0 otherwise.
- R8: A read while `pdn_n` is 0 returns 0 on `rdata`. A write while `pdn_n` is 0 has no effect.
- R9: After `pdn_n` rises, writes at the first two clock edges are ignored. A write at the third edge is accepted.
- R10: A write at edge E appears on the control outputs after edge E+1. A read strobe at edge E presents data after edge E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as power-down |
| pdn_n | input | 1 | Hard power-down pin, active low |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W | Registered read data |
| user_bit_in | input | 1 | Recovered user data bit |
| pll_clk_en | output | 1 | PLL clock enable |
| xtal_clk_en | output | 1 | Crystal clock enable |
| timing_rst | output | 1 | Reset for the frame and bit counters |
| sdata_force_low | output | 1 | Forces serial audio data output low |
| rx_sel | output | 1 | Receiver input select |
| user_bit_out | output | 1 | Gated user data bit |

## Verification
The bench drives random writes to both registers and to unmapped addresses. It biases the soft-reset bit mostly high so that runs of normal operation alternate with soft resets, and it mixes in random power-down pulses with reads issued during them. This separates a design that clears the protected clocking fields on soft reset from one that keeps them. It also separates a design that drops writes to register 1 only while soft reset is active from one that drops them always or never. Directed cases cover the exact edge on which writes resume after power-down release and the level of the user bit with the gate open and closed. After every step, readback of both registers and all six outputs are compared against a bench model.

// File: rtl/rcv_ctrl_pkg.sv
package rcv_ctrl_pkg;

  localparam int unsigned REG_CLK  = 0;
  localparam int unsigned REG_PATH = 1;

  typedef struct packed {
    logic       srst_n;
    logic       pwr_n;
    logic [1:0] xtal_sel;
    logic       ext_clk;
    logic       in_sel;
    logic       ubit_en;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{
    srst_n:   1'b1,
    pwr_n:    1'b1,
    xtal_sel: 2'b00,
    ext_clk:  1'b0,
    in_sel:   1'b0,
    ubit_en:  1'b0
  };

endpackage

// File: rtl/rcv_pdn_sync.sv
module rcv_pdn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_n,
  output logic hold
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst || !pdn_n) chain_q <= '0;
    else               chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  // Hold covers reset, the raw pin and the window until the release has crossed.
  assign hold = rst || !pdn_n || !chain_q[STAGES-1];

  // R9: access only opens after the pin has been high at the two prior edges
  assert_sync_release_R9: assert property (@(posedge clk) disable iff (rst)
    !hold |-> ($past(pdn_n) && $past(pdn_n, 2)));

endmodule

// File: rtl/rcv_ctrl_file.sv
module rcv_ctrl_file
  import rcv_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             cfg
);

  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(REG_CLK);
  localparam logic [ADDR_W-1:0] A_PATH = ADDR_W'(REG_PATH);

  ctrl_t cfg_q;
  ctrl_t cfg_d;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en && addr == A_CLK) begin
      cfg_d.srst_n   = wdata[0];
      cfg_d.pwr_n    = wdata[1];
      cfg_d.xtal_sel = wdata[3:2];
      cfg_d.ext_clk  = wdata[4];
    end
    if (wr_en && addr == A_PATH && cfg_q.srst_n) begin
      cfg_d.in_sel  = wdata[0];
      cfg_d.ubit_en = wdata[1];
    end
    // Unprotected fields sit at default for as long as soft reset is active.
    if (!cfg_d.srst_n) begin
      cfg_d.in_sel  = CTRL_DEFAULT.in_sel;
      cfg_d.ubit_en = CTRL_DEFAULT.ubit_en;
    end
  end

  always_ff @(posedge clk) begin
    if (hold) cfg_q <= CTRL_DEFAULT;
    else      cfg_q <= cfg_d;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CLK)
      rd_mux = DATA_W'({cfg_q.ext_clk, cfg_q.xtal_sel, cfg_q.pwr_n, cfg_q.srst_n});
    else if (addr == A_PATH)
      rd_mux = DATA_W'({cfg_q.ubit_en, cfg_q.in_sel});
  end

  always_ff @(posedge clk) begin
    if (hold || !rd_en) rdata <= '0;
    else                rdata <= rd_mux;
  end

  assign cfg = cfg_q;

  // R3: with soft reset active the unprotected fields stay at default
  assert_soft_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!hold && !cfg_q.srst_n) |=> (cfg_q.in_sel == 1'b0 && cfg_q.ubit_en == 1'b0));

  // R5: the power bit alone leaves the path fields untouched
  assert_pwr_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (!hold && cfg_q.srst_n && !wr_en) |=> $stable(cfg_q));

endmodule

// File: rtl/rcv_ctrl_out.sv
module rcv_ctrl_out
  import rcv_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  ctrl_t cfg,
  input  logic  user_bit_in,
  output logic  pll_clk_en,
  output logic  xtal_clk_en,
  output logic  timing_rst,
  output logic  sdata_force_low,
  output logic  rx_sel,
  output logic  user_bit_out
);

  always_ff @(posedge clk) begin
    xtal_clk_en     <= !hold;
    pll_clk_en      <= !hold && cfg.pwr_n;
    timing_rst      <= hold || !cfg.srst_n;
    sdata_force_low <= hold || !cfg.srst_n;
    rx_sel          <= !hold && cfg.in_sel;
    user_bit_out    <= !hold && cfg.ubit_en && user_bit_in;
  end

  // R4: soft reset keeps the crystal clock but gags data and timing
  assert_soft_out_R4: assert property (@(posedge clk) disable iff (rst)
    (!hold && !cfg.srst_n) |=> (sdata_force_low && timing_rst && xtal_clk_en));

  // R5: power bit low stops only the PLL enable
  assert_pwr_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!hold && !cfg.pwr_n) |=> (!pll_clk_en && xtal_clk_en));

  // R7: closed gate means a quiet user output
  assert_ubit_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg.ubit_en |=> !user_bit_out);

endmodule

// File: rtl/rcv_ctrl_regs.sv
module rcv_ctrl_regs
  import rcv_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              user_bit_in,
  output logic              pll_clk_en,
  output logic              xtal_clk_en,
  output logic              timing_rst,
  output logic              sdata_force_low,
  output logic              rx_sel,
  output logic              user_bit_out
);

  logic  hold;
  ctrl_t cfg;

  rcv_pdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pdn_n (pdn_n),
    .hold  (hold)
  );

  rcv_ctrl_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_file (
    .clk   (clk),
    .rst   (rst),
    .hold  (hold),
    .addr  (addr),
    .wdata (wdata),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .cfg   (cfg)
  );

  rcv_ctrl_out u_out (
    .clk             (clk),
    .rst             (rst),
    .hold            (hold),
    .cfg             (cfg),
    .user_bit_in     (user_bit_in),
    .pll_clk_en      (pll_clk_en),
    .xtal_clk_en     (xtal_clk_en),
    .timing_rst      (timing_rst),
    .sdata_force_low (sdata_force_low),
    .rx_sel          (rx_sel),
    .user_bit_out    (user_bit_out)
  );

  // R1: the pin shuts both clock enables and asserts the timing reset
  assert_pd_clocks_R1: assert property (@(posedge clk) disable iff (rst)
    !pdn_n |=> (!xtal_clk_en && !pll_clk_en && timing_rst && sdata_force_low));

  // R8: reads during power-down return zero
  assert_pd_read_R8: assert property (@(posedge clk) disable iff (rst)
    !pdn_n |=> (rdata == '0));

endmodule

// File: tb/rcv_ctrl_regs_tb.sv
`timescale 1ns/1ps
module rcv_ctrl_regs_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pdn_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       user_bit_in = 1'b0;
  logic       pll_clk_en, xtal_clk_en, timing_rst, sdata_force_low, rx_sel, user_bit_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model
  bit m_srst_n, m_pwr_n, m_ext, m_sel, m_uen, m_pd;
  bit [1:0] m_xtal;

  always #2.5 clk = ~clk;

  rcv_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .pdn_n(pdn_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .user_bit_in(user_bit_in),
    .pll_clk_en(pll_clk_en), .xtal_clk_en(xtal_clk_en), .timing_rst(timing_rst),
    .sdata_force_low(sdata_force_low), .rx_sel(rx_sel), .user_bit_out(user_bit_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void m_defaults();
    m_srst_n = 1; m_pwr_n = 1; m_xtal = 0; m_ext = 0; m_sel = 0; m_uen = 0;
  endfunction

  function automatic bit [7:0] exp_reg(input int a);
    if (m_pd) return 8'h00;
    if (a == 0) return {3'b000, m_ext, m_xtal, m_pwr_n, m_srst_n};
    if (a == 1) return {6'b0, m_uen, m_sel};
    return 8'h00;
  endfunction

  function automatic void m_write(input int a, input bit [7:0] d);
    if (a == 0) begin
      m_srst_n = d[0]; m_pwr_n = d[1]; m_xtal = d[3:2]; m_ext = d[4];
    end else if (a == 1 && m_srst_n) begin
      m_sel = d[0]; m_uen = d[1];
    end
    if (!m_srst_n) begin m_sel = 0; m_uen = 0; end
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_write(input int a, input bit [7:0] d);
    addr = 4'(a); wdata = d; wr_en = 1;
    cyc();
    wr_en = 0;
  endtask

  task automatic bus_read_chk(input int a, input string req);
    addr = 4'(a); rd_en = 1;
    cyc();
    rd_en = 0;
    chk(rdata == exp_reg(a), req, $sformatf("read addr %0d", a), rdata, exp_reg(a));
  endtask

  task automatic out_chk(input string req);
    bit e_xt, e_pll, e_rst, e_sel, e_ub;
    e_xt  = !m_pd;
    e_pll = !m_pd && m_pwr_n;
    e_rst = m_pd || !m_srst_n;
    e_sel = !m_pd && m_sel;
    e_ub  = !m_pd && m_uen && user_bit_in;
    chk(xtal_clk_en == e_xt, req, "xtal_clk_en", xtal_clk_en, e_xt);
    chk(pll_clk_en == e_pll, req, "pll_clk_en", pll_clk_en, e_pll);
    chk(timing_rst == e_rst, req, "timing_rst", timing_rst, e_rst);
    chk(sdata_force_low == e_rst, req, "sdata_force_low", sdata_force_low, e_rst);
    chk(rx_sel == e_sel, req, "rx_sel", rx_sel, e_sel);
    chk(user_bit_out == e_ub, req, "user_bit_out", user_bit_out, e_ub);
  endtask

  // power-down pulse; reads and writes during it must be refused (R1, R8)
  task automatic pd_pulse(input int len);
    pdn_n = 0;
    cyc();
    m_pd = 1; m_defaults();
    out_chk("R1");
    for (int i = 0; i < len; i++) begin
      bus_write(1, 8'h03);
      bus_read_chk(0, "R8");
    end
    pdn_n = 1;
    m_pd = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_defaults();
    m_pd = 1;
    repeat (3) cyc();
    out_chk("R1");
    rst = 0;
    m_pd = 0;
    repeat (4) cyc();
    out_chk("R2");
    bus_read_chk(0, "R2");
    bus_read_chk(1, "R2");

    // input select and user bit gate
    bus_write(1, 8'h03); m_write(1, 8'h03);
    user_bit_in = 1; cyc();
    out_chk("R6"); out_chk("R7");
    user_bit_in = 0; cyc();
    out_chk("R7");
    bus_write(1, 8'h01); m_write(1, 8'h01);
    user_bit_in = 1; cyc();
    out_chk("R7");
    bus_write(1, 8'h02); m_write(1, 8'h02);
    cyc(); out_chk("R6");
    bus_write(1, 8'h03); m_write(1, 8'h03);

    // R10: outputs lag the register write by one edge
    bus_write(1, 8'h00);
    chk(rx_sel == 1'b1, "R10", "rx_sel one edge after write", rx_sel, 1);
    m_write(1, 8'h00);
    cyc();
    chk(rx_sel == 1'b0, "R10", "rx_sel two edges after write", rx_sel, 0);
    bus_write(1, 8'h03); m_write(1, 8'h03);

    // power bit
    bus_write(0, 8'h01); m_write(0, 8'h01);
    cyc(); out_chk("R5");
    bus_read_chk(1, "R5");
    bus_write(1, 8'h02); m_write(1, 8'h02);
    bus_read_chk(1, "R5");

    // soft reset with protected fields set
    bus_write(0, 8'h1E); m_write(0, 8'h1E);
    cyc(); out_chk("R4");
    bus_read_chk(0, "R3");
    bus_read_chk(1, "R3");
    bus_write(1, 8'h03); m_write(1, 8'h03);
    cyc(); out_chk("R3");
    bus_read_chk(1, "R3");
    bus_write(0, 8'hFF); m_write(0, 8'hFF);
    bus_read_chk(0, "R2");
    bus_write(5, 8'hFF);
    bus_read_chk(5, "R2");
    bus_read_chk(0, "R2");

    // release window: first two edges refused
    bus_write(0, 8'h0F); m_write(0, 8'h0F);
    pd_pulse(2);
    bus_write(1, 8'h01);
    bus_write(0, 8'h07);
    cyc();
    bus_read_chk(0, "R9");
    bus_read_chk(1, "R9");
    pd_pulse(1);
    cyc(); cyc();
    bus_write(1, 8'h02); m_write(1, 8'h02);
    bus_read_chk(1, "R9");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 12;
      if (op == 0) begin
        pd_pulse(1 + ($urandom % 3));
        repeat (3) cyc();
      end else begin
        int a;
        bit [7:0] d;
        a = $urandom % 4;
        d = 8'($urandom);
        if (a == 0) d[0] = (($urandom % 4) != 0);
        bus_write(a, d); m_write(a, d);
      end
      user_bit_in = 1'($urandom);
      cyc();
      out_chk("R3");
      bus_read_chk(0, "R2");
      bus_read_chk(1, "R3");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule